// File: doc/BRIEF.md
# Dual-Address DMA Transfer Channel

This block is one DMA channel that copies data between two locations in memory. Each accepted request moves one data unit, either a byte or a 16-bit word. The channel first reads the unit from the source pointer and then writes it to the destination pointer. After the write, each pointer moves on its own: up, down, or not at all. The step is 1 for bytes and 2 for words. A transfer counter counts down once per unit. When it runs out, the channel disables itself and can raise an interrupt.

Software sets up the channel through a write-only register port, using one select code per register:

| Select | Register | Contents |
|---|---|---|
| 0 | Source pointer | 24 bits |
| 1 | Destination pointer | 24 bits |
| 2 | Transfer counter | 16 bits |
| 3 | Control word | Fields listed in R1 |
| 4 | Interrupt acknowledge | Any value |

After setup, some other agent pulses `xfer_req` once per unit to be moved.

The memory side is a single master port with a read strobe and a write strobe. Each strobe works like a valid signal, and `bus_ready` works like its ready. The memory applies back-pressure by holding `bus_ready` low. While it does so, the strobe, the address, the size and the write data stay frozen. The access completes on the first rising edge at which the strobe and `bus_ready` are both high. `bus_ready` has no effect while no strobe is active.

Top module: `dma_xfer_chan`

## Requirements
- R1: The channel accepts a request only when the control word has all three of these bits set as shown: enable (bit 0) = 1, normal-mode select (bit 7) = 1, and block-mode select (bit 8) = 0. In every other case a pulse on `xfer_req` causes no bus activity.
- R2: An accepted request asserts `bus_rd` at the source pointer in the cycle after the edge that sampled the request. The read completes on the edge where `bus_ready` is high. `bus_wr` at the destination pointer follows in the next cycle. Each strobe holds its address and data stable until `bus_ready`, and the two strobes are never high together.
- R3: Control bit 2 selects word size. When it is 1, `bus_size` is 1 during the access and all 16 bits that were read are written. When it is 0, `bus_size` is 0 and the written value is the low byte read, with the upper byte driven to zero.
- R4: After each completed write, each pointer is updated according to its own 2-bit mode field (source in bits 4:3, destination in bits 6:5). A mode of 1 adds the step, a mode of 2 subtracts it, and 0 or 3 leaves the pointer unchanged. The step is 2 for words and 1 for bytes.
- R5: Pointer arithmetic wraps modulo 2^24: stepping down from 0 reaches 0xFFFFFF, and stepping up from 0xFFFFFE by 2 reaches 0.
- R6: The counter drops by one on each completed write. The write that brings it to zero clears the enable bit, and later requests are ignored.
- R7: A counter loaded with 0 first wraps to 0xFFFF, so the channel keeps running for 65,536 transfers in total.
- R8: If control bit 1 (interrupt enable) is set when the counter reaches zero, `irq` rises one cycle after the final write completes. It stays high until select 4 or select 3 is written. If bit 1 is clear, `irq` stays low.
- R9: A request that arrives while a transfer is still in progress is dropped. It is not queued.
- R10: After reset, both strobes are low, `irq` is low, and the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 source, 1 destination, 2 counter, 3 control, 4 interrupt acknowledge) |
| cfg_wdata | input | 32 | Register write data |
| xfer_req | input | 1 | Request pulse for one unit transfer |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_size | output | 1 | 1 for a word access, 0 for a byte access |
| bus_addr | output | 24 | Access address (zero when idle) |
| bus_wdata | output | 16 | Write data (zero when not writing) |
| bus_rdata | input | 16 | Read data, taken when `bus_rd` and `bus_ready` are both high |
| bus_ready | input | 1 | Access completion handshake |
| irq | output | 1 | End-of-transfer interrupt, level |

## Verification
Each result has a fixed due cycle, counted from the rising edge that caused it:
- The read strobe is due one cycle after the edge that samples a request.
- The write strobe is due one cycle after the edge that completes the read.
- Pointer steps, counter steps, enable clearing and `irq` are all due one cycle after the edge that completes the write.
- Register writes take effect in the cycle after the edge that samples them.

The bench keeps a behavioural model that it advances on the same rising edges. It compares the strobes, size, address, write data and `irq` against the model on every falling edge, so each comparison lands half a cycle after the edge its value depends on. The bench's memory model lowers `bus_ready` for a programmable number of cycles, which also exercises the hold-under-back-pressure behaviour.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  // Pointer update modes (2-bit field in the control word)
  typedef enum logic [1:0] {
    AM_HOLD  = 2'd0,
    AM_UP    = 2'd1,
    AM_DOWN  = 2'd2,
    AM_HOLD2 = 2'd3
  } addr_mode_e;

  // Bus sequencer states
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WRITE = 2'd2
  } seq_state_e;

  // Control word bit positions
  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_IE   = 1;
  localparam int unsigned CTL_WORD = 2;
  localparam int unsigned CTL_SM   = 3;
  localparam int unsigned CTL_DM   = 5;
  localparam int unsigned CTL_FAE  = 7;
  localparam int unsigned CTL_BLK  = 8;
  localparam int unsigned CTL_W    = 9;

  // Register select codes
  localparam int unsigned SEL_SRC = 0;
  localparam int unsigned SEL_DST = 1;
  localparam int unsigned SEL_CNT = 2;
  localparam int unsigned SEL_CTL = 3;
  localparam int unsigned SEL_ACK = 4;

  typedef struct packed {
    logic       blk;
    logic       fae;
    addr_mode_e dm;
    addr_mode_e sm;
    logic       word;
    logic       ie;
  } chan_ctl_t;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned CFGW = 32,
  parameter int unsigned SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [CFGW-1:0] cfg_wdata,
  input  logic            xfer_done,
  output chan_ctl_t       ctl,
  output logic            chan_en,
  output logic            irq,
  output logic            ld_src,
  output logic            ld_dst,
  output logic            ld_cnt
);

  logic wr_ctl;
  logic wr_ack;
  logic unused_hi;

  // Write decode
  assign ld_src = cfg_we && (cfg_sel == SELW'(SEL_SRC));
  assign ld_dst = cfg_we && (cfg_sel == SELW'(SEL_DST));
  assign ld_cnt = cfg_we && (cfg_sel == SELW'(SEL_CNT));
  assign wr_ctl = cfg_we && (cfg_sel == SELW'(SEL_CTL));
  assign wr_ack = cfg_we && (cfg_sel == SELW'(SEL_ACK));

  assign unused_hi = ^cfg_wdata[CFGW-1:CTL_W];

  // Control fields and enable: a software write beats end-of-count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      chan_en <= 1'b0;
    end else if (wr_ctl) begin
      ctl.ie   <= cfg_wdata[CTL_IE];
      ctl.word <= cfg_wdata[CTL_WORD];
      ctl.sm   <= addr_mode_e'(cfg_wdata[CTL_SM +: 2]);
      ctl.dm   <= addr_mode_e'(cfg_wdata[CTL_DM +: 2]);
      ctl.fae  <= cfg_wdata[CTL_FAE];
      ctl.blk  <= cfg_wdata[CTL_BLK];
      chan_en  <= cfg_wdata[CTL_EN];
    end else if (xfer_done) begin
      chan_en <= 1'b0;
    end
  end

  // Interrupt flag: cleared by acknowledge or control rewrite
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (wr_ctl || wr_ack) begin
      irq <= 1'b0;
    end else if (xfer_done && ctl.ie) begin
      irq <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step_en,
  input  addr_mode_e    mode,
  input  logic          word,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] mag;
  logic [AW-1:0] nxt;

  assign mag = word ? AW'(2) : AW'(1);

  // Step arithmetic wraps modulo 2^AW
  always_comb begin
    unique case (mode)
      AM_UP:   nxt = addr + mag;
      AM_DOWN: nxt = addr - mag;
      default: nxt = addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (step_en) begin
      addr <= nxt;
    end
  end

endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);

  logic [CW-1:0] cnt_q;

  // One left means this transfer is final; a stored zero wraps to all-ones
  assign last = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic          word,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_size,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          step,
  output logic          idle
);

  localparam int unsigned BW = 8;

  seq_state_e    st_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      data_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (start) st_q <= SQ_READ;
        end
        SQ_READ: begin
          if (bus_ready) begin
            data_q <= bus_rdata;
            st_q   <= SQ_WRITE;
          end
        end
        SQ_WRITE: begin
          if (bus_ready) st_q <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign bus_rd   = (st_q == SQ_READ);
  assign bus_wr   = (st_q == SQ_WRITE);
  assign idle     = (st_q == SQ_IDLE);
  assign bus_size = !idle && word;
  assign step     = bus_wr && bus_ready;

  always_comb begin
    bus_addr = '0;
    if (bus_rd) bus_addr = src_addr;
    else if (bus_wr) bus_addr = dst_addr;
  end

  always_comb begin
    bus_wdata = '0;
    if (bus_wr) begin
      bus_wdata = word ? data_q : {{(DW-BW){1'b0}}, data_q[BW-1:0]};
    end
  end

endmodule

// File: rtl/dma_xfer_chan.sv
module dma_xfer_chan
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW   = 24,
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned CFGW = 32,
  parameter int unsigned SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [CFGW-1:0] cfg_wdata,
  input  logic            xfer_req,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic            bus_size,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            bus_ready,
  output logic            irq
);

  localparam int unsigned NPTR = 2;  // index 0 source, 1 destination

  chan_ctl_t  ctl;
  logic       chan_en;
  logic       ld_src, ld_dst, ld_cnt;
  logic       step, seq_idle, cnt_last, start, xfer_done;
  logic [AW-1:0] ptr_q  [NPTR];
  logic          ptr_ld [NPTR];
  addr_mode_e    ptr_md [NPTR];

  assign ptr_ld[0] = ld_src;
  assign ptr_ld[1] = ld_dst;
  assign ptr_md[0] = ctl.sm;
  assign ptr_md[1] = ctl.dm;

  assign start     = xfer_req && chan_en && ctl.fae && !ctl.blk && seq_idle;
  assign xfer_done = step && cnt_last;

  dma_cfg_regs #(.CFGW(CFGW), .SELW(SELW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .xfer_done (xfer_done),
    .ctl       (ctl),
    .chan_en   (chan_en),
    .irq       (irq),
    .ld_src    (ld_src),
    .ld_dst    (ld_dst),
    .ld_cnt    (ld_cnt)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_addr_reg #(.AW(AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_ld[g]),
      .load_val (cfg_wdata[AW-1:0]),
      .step_en  (step),
      .mode     (ptr_md[g]),
      .word     (ctl.word),
      .addr     (ptr_q[g])
    );
  end

  dma_xfer_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld_cnt),
    .load_val (cfg_wdata[CW-1:0]),
    .dec      (step),
    .last     (cnt_last)
  );

  dma_bus_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src_addr  (ptr_q[0]),
    .dst_addr  (ptr_q[1]),
    .word      (ctl.word),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .step      (step),
    .idle      (seq_idle)
  );

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready,
  input logic          irq,
  input logic          chan_en
);

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_ready |=> bus_rd && $stable(bus_addr));

  p_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_ready |=> bus_wr && $stable(bus_addr) && $stable(bus_wdata));

  p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_ready |=> bus_wr);

  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en && !bus_rd && !bus_wr |=> !bus_rd);

  p_busy_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_ready |=> !bus_rd && !bus_wr);

  p_irq_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(bus_wr && bus_ready));

  p_en_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chan_en) && !$past(cfg_we) |-> $past(bus_wr && bus_ready));

endmodule

bind dma_xfer_chan dma_chan_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ready (bus_ready),
  .irq       (irq),
  .chan_en   (chan_en)
);

// File: tb/sim_dma_xfer_chan.sv
`timescale 1ns/1ps
module sim_dma_xfer_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        xfer_req = 1'b0;
  logic        bus_rd, bus_wr, bus_size, irq;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;

  always #5 clk = ~clk;

  dma_xfer_chan u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .xfer_req(xfer_req), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .irq(irq)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] fmem(logic [23:0] a);
    return {a[15:8] + a[23:16], a[7:0] ^ 8'hA5};
  endfunction

  function automatic logic [23:0] upd(logic [23:0] a, logic [1:0] md, bit wd);
    logic [23:0] s = wd ? 24'd2 : 24'd1;
    if (md == 2'd1) return a + s;
    if (md == 2'd2) return a - s;
    return a;
  endfunction

  function automatic logic [31:0] mk_ctl(bit en, bit ie, bit wd, logic [1:0] sm,
                                         logic [1:0] dm, bit fae, bit blk);
    return {23'd0, blk, fae, dm, sm, wd, ie, en};
  endfunction

  // Behavioural reference model
  int          m_st = 0;
  logic [23:0] m_src = '0, m_dst = '0;
  int          m_cnt = 0;
  bit          m_en = 0, m_ie = 0, m_word = 0, m_fae = 0, m_blk = 0;
  logic [1:0]  m_sm = '0, m_dm = '0;
  bit          m_irq = 0;
  logic [15:0] m_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_src = '0; m_dst = '0; m_cnt = 0; m_en = 0; m_ie = 0;
      m_word = 0; m_fae = 0; m_blk = 0; m_sm = '0; m_dm = '0; m_irq = 0;
      m_data = '0;
    end else begin
      case (m_st)
        0: if (xfer_req && m_en && m_fae && !m_blk) m_st = 1;
        1: if (bus_ready) begin m_data = fmem(m_src); m_st = 2; end
        2: if (bus_ready) begin
             m_src = upd(m_src, m_sm, m_word);
             m_dst = upd(m_dst, m_dm, m_word);
             m_cnt = (m_cnt - 1) & 16'hFFFF;
             if (m_cnt == 0) begin m_en = 0; if (m_ie) m_irq = 1; end
             m_st = 0;
           end
        default: m_st = 0;
      endcase
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: m_src = cfg_wdata[23:0];
          3'd1: m_dst = cfg_wdata[23:0];
          3'd2: m_cnt = int'(cfg_wdata[15:0]);
          3'd3: begin
            m_en = cfg_wdata[0]; m_ie = cfg_wdata[1]; m_word = cfg_wdata[2];
            m_sm = cfg_wdata[4:3]; m_dm = cfg_wdata[6:5];
            m_fae = cfg_wdata[7]; m_blk = cfg_wdata[8]; m_irq = 0;
          end
          3'd4: m_irq = 0;
          default: ;
        endcase
      end
    end
  end

  // Per-cycle compare and memory responder, half a cycle after each edge
  int          lat = 0;
  int          wc = 0;
  int          act_wr = 0;
  logic [23:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [15:0] last_wdata = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 bus_rd", bus_rd, m_st == 1);
      chk("R2 bus_wr", bus_wr, m_st == 2);
      chk("R4 bus_addr", bus_addr, (m_st == 1) ? m_src : (m_st == 2) ? m_dst : 24'd0);
      chk("R3 bus_size", bus_size, (m_st != 0) && m_word);
      chk("R3 bus_wdata", bus_wdata,
          (m_st == 2) ? (m_word ? m_data : {8'h00, m_data[7:0]}) : 16'd0);
      chk("R8 irq", irq, m_irq);
    end
    bus_rdata = fmem(bus_addr);
    bus_ready = (bus_rd || bus_wr) && (wc >= lat);
    if ((bus_rd || bus_wr) && !bus_ready) wc++; else wc = 0;
    if (bus_rd && bus_ready) last_rd_addr = bus_addr;
    if (bus_wr && bus_ready) begin
      act_wr++; last_wr_addr = bus_addr; last_wdata = bus_wdata;
    end
  end

  task automatic cfg_write(int sel, logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
    repeat (2) @(negedge clk);
    while (m_st != 0) @(negedge clk);
  endtask

  task automatic setup(logic [23:0] s, logic [23:0] d, int n, logic [31:0] c);
    cfg_write(0, {8'd0, s});
    cfg_write(1, {8'd0, d});
    cfg_write(2, 32'(n));
    cfg_write(3, c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rd after reset", bus_rd, 0);
    chk("R10 wr after reset", bus_wr, 0);
    chk("R10 irq after reset", irq, 0);
    base = act_wr; pulse_req();
    chk("R10 disabled after reset", act_wr - base, 0);

    // R1: mode gating
    setup(24'h100, 24'h200, 4, mk_ctl(0, 0, 1, 2'd1, 2'd1, 1, 0));
    base = act_wr; pulse_req();
    chk("R1 enable off ignored", act_wr - base, 0);
    cfg_write(3, mk_ctl(1, 0, 1, 2'd1, 2'd1, 0, 0));
    base = act_wr; pulse_req();
    chk("R1 normal select off ignored", act_wr - base, 0);
    cfg_write(3, mk_ctl(1, 0, 1, 2'd1, 2'd1, 1, 1));
    base = act_wr; pulse_req();
    chk("R1 block select on ignored", act_wr - base, 0);

    // Main word run: source up, destination down
    lat = 0;
    setup(24'h000100, 24'h000400, 3, mk_ctl(1, 1, 1, 2'd1, 2'd2, 1, 0));
    base = act_wr;
    for (int i = 0; i < 3; i++) pulse_req();
    chk("R2 three transfers done", act_wr - base, 3);
    chk("R4 last source read", last_rd_addr, 24'h000104);
    chk("R4 last destination write", last_wr_addr, 24'h0003FC);
    chk("R3 word data", last_wdata, fmem(24'h000104));
    @(negedge clk);
    chk("R8 irq at end", irq, 1);
    base = act_wr; pulse_req();
    chk("R6 request after end ignored", act_wr - base, 0);
    cfg_write(4, 32'd0);
    @(negedge clk);
    chk("R8 irq cleared by acknowledge", irq, 0);

    // Byte run with source wrap and slow memory, no interrupt
    lat = 2;
    setup(24'h000001, 24'h000050, 3, mk_ctl(1, 0, 0, 2'd2, 2'd0, 1, 0));
    base = act_wr;
    for (int i = 0; i < 3; i++) pulse_req();
    chk("R2 byte transfers done", act_wr - base, 3);
    chk("R5 source wrapped down", last_rd_addr, 24'hFFFFFF);
    chk("R4 fixed destination", last_wr_addr, 24'h000050);
    chk("R3 byte data upper zero", last_wdata, 16'h005A);
    @(negedge clk);
    chk("R8 no irq when disabled", irq, 0);

    // Destination wrap up, then control rewrite clears irq
    lat = 1;
    setup(24'h000010, 24'hFFFFFE, 2, mk_ctl(1, 1, 1, 2'd0, 2'd1, 1, 0));
    base = act_wr;
    for (int i = 0; i < 2; i++) pulse_req();
    chk("R5 destination wrapped up", last_wr_addr, 24'h000000);
    @(negedge clk);
    chk("R8 irq raised", irq, 1);
    cfg_write(3, mk_ctl(0, 1, 1, 2'd0, 2'd1, 1, 0));
    @(negedge clk);
    chk("R8 irq cleared by control write", irq, 0);

    // Zero count runs on
    lat = 0;
    setup(24'h000200, 24'h000300, 0, mk_ctl(1, 1, 1, 2'd1, 2'd1, 1, 0));
    base = act_wr;
    for (int i = 0; i < 6; i++) pulse_req();
    chk("R7 zero count keeps running", act_wr - base, 6);
    chk("R7 no end irq", irq, 0);

    // Request while busy is dropped
    lat = 4;
    setup(24'h000600, 24'h000700, 5, mk_ctl(1, 0, 1, 2'd1, 2'd1, 1, 0));
    base = act_wr;
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
    while (m_st != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R9 busy request dropped", act_wr - base, 1);
    base = act_wr; pulse_req();
    chk("R6 channel still enabled mid-count", act_wr - base, 1);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule